// File: doc/BRIEF.md
# Indexed Block Configuration Slave for a Clock Fanout Buffer

This block is the two-wire serial management slave of a nine-lane clock fanout buffer. It holds a small bank of eight configuration bytes, and it drives the lane enables, the per-lane edge-rate selects and the output swing code straight from that bank. The serial clock and data lines are oversampled by the system clock, and the block detects start conditions, stop conditions and clock edges itself. It pulls the data line low through an open-drain enable.

A host writes by sending the slave address with the write bit, a starting index, a byte count and then that many data bytes. The slave stores each data byte at the current index and then advances the index. A host reads by sending the write address and an index, then a repeated start and the read address. The slave answers with a byte count taken from its own count register, and then sends bytes from the index onward until the host refuses one. The 7-bit slave address is chosen by a three-state strap. The strap is captured once, at the first rising edge of the power-good input. Bus traffic is served only while the reference clock is reported present.

Top module: `smb_cfg_slave`

## Requirements
- R1: The strap code picks the slave address: 2'b00 (low) gives 7'h6B, 2'b01 (mid) gives 7'h6C, 2'b10 (high) gives 7'h6D, and 2'b11 (floating) is taken as mid. Any other address byte is not acknowledged.
- R2: The strap is captured only at the first rising edge of power-good after reset. Later power-good cycles or strap changes do not alter the address, and before that first edge no address is acknowledged.
- R3: An indexed block write (address with write bit 0, index N, count X, X data bytes) acknowledges every byte and stores the data at N through N+X-1. A data byte sent after X bytes is not acknowledged and is not stored.
- R4: An indexed read (address with write bit, index N, repeated start, address with read bit 1) returns the count byte first, then bytes N, N+1, and so on. Bits are sent MSB first, and each byte is acknowledged by the host until the host refuses one.
- R5: After reset the bank reads byte0=FF, byte1=22, byte2=FF, byte3=01, byte4=FF, byte5=01, byte6=C9 and byte7=08. The outputs are lane_en={byte1[5],byte0}, slew_fast={byte3[0],byte2} and amp_sel=byte1[1:0].
- R6: Writes to bytes 4, 5 and 6, and to indexes above 7, are acknowledged and discarded. Byte1 keeps only bits 5 and 1:0, byte3 keeps only bit 0 and byte7 keeps only bits 4:0; the other bits read 0. Indexes above 7 read FF.
- R7: The count byte returned first by a read equals byte7[4:0], and the host can write it.
- R8: While clk_present is low the slave stays idle: it acknowledges nothing, stores nothing and does not drive SDA.
- R9: A start or stop condition in the middle of a byte aborts the transfer and leaves the bank unchanged. A stop clears the index, so a read address sent without a preceding index is not acknowledged.
- R10: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_present | input | 1 | High while the reference clock is running |
| pwrgd | input | 1 | Power-good; its first rising edge captures the strap |
| addr_strap | input | 2 | Three-state address strap code (00 low, 01 mid, 10 high) |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| lane_en | output | 9 | Per-lane output enable |
| amp_sel | output | 2 | Output swing code |
| slew_fast | output | 9 | Per-lane fast edge-rate select |

## Verification
The bit shifter and the start/stop detector both react to the same sampled SDA and SCL, so a stop or a repeated start can land in the cycle in which a byte would otherwise complete. The bench provokes this by cutting a data byte short after a few bits with a stop, and with a repeated start that opens a fresh write. It then judges the outcome at the lane and edge-rate outputs: the aborted byte must leave no trace, and the fresh transfer must land intact. A second collision, a read address arriving after a stop has cleared the index, must be refused.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int IDX_W   = 8;
  localparam int CNT_W   = 5;
  localparam int NUM_REG = 8;

  localparam logic [ADDR_W-1:0] ADDR_LOW  = 7'h6B;
  localparam logic [ADDR_W-1:0] ADDR_MID  = 7'h6C;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 7'h6D;

  localparam logic [BYTE_W-1:0] ID_VENDOR = 8'h01;
  localparam logic [BYTE_W-1:0] ID_DEVICE = 8'hC9;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
  localparam logic [CNT_W-1:0]  CNT_RST   = 5'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA, ST_ACK, ST_TX, ST_TX_ACK
  } link_st_t;

  typedef enum logic [1:0] {
    NX_INDEX, NX_COUNT, NX_WDATA, NX_TXCNT
  } after_ack_t;

  function automatic logic [ADDR_W-1:0] strap_to_addr(input logic [1:0] code);
    case (code)
      2'b00:   return ADDR_LOW;
      2'b10:   return ADDR_HIGH;
      default: return ADDR_MID;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sampler.sv
module smb_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync_q, sda_sync_q;
  logic         scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[TOP-1:0], scl_i};
      sda_sync_q <= {sda_sync_q[TOP-1:0], sda_i};
      scl_d_q    <= scl_sync_q[TOP];
      sda_d_q    <= sda_sync_q[TOP];
    end
  end

  assign scl_s     = scl_sync_q[TOP];
  assign sda_s     = sda_sync_q[TOP];
  assign scl_rise  =  scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s &  scl_d_q;
  assign start_det =  scl_s &  scl_d_q &  sda_d_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_d_q & ~sda_d_q &  sda_s;

endmodule

// File: rtl/smb_addr_strap.sv
module smb_addr_strap
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd,
  input  logic [1:0]        addr_strap,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              addr_valid
);

  logic [1:0]        pg_sync_q;
  logic              pg_d_q;
  logic              pg_rise;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign pg_rise = pg_sync_q[1] & ~pg_d_q;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    if (pg_rise && !valid_q) begin
      valid_d = 1'b1;
      addr_d  = strap_to_addr(addr_strap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_sync_q <= '0;
      pg_d_q    <= 1'b0;
      valid_q   <= 1'b0;
      addr_q    <= '0;
    end else begin
      pg_sync_q <= {pg_sync_q[0], pwrgd};
      pg_d_q    <= pg_sync_q[1];
      valid_q   <= valid_d;
      addr_q    <= addr_d;
    end
  end

  assign dev_addr   = addr_q;
  assign addr_valid = valid_q;

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> (valid_q && $stable(addr_q))); // R2

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_count,
  output logic [8:0]        lane_en,
  output logic [1:0]        amp_sel,
  output logic [8:0]        slew_fast
);

  logic [7:0]       en_q, en_d, slew_q, slew_d;
  logic             en8_q, en8_d, slew8_q, slew8_d;
  logic [1:0]       amp_q, amp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    en_d    = en_q;
    en8_d   = en8_q;
    amp_d   = amp_q;
    slew_d  = slew_q;
    slew8_d = slew8_q;
    cnt_d   = cnt_q;
    if (wr_en) begin
      case (wr_idx)
        8'd0: en_d = wr_data;
        8'd1: begin
          en8_d = wr_data[5];
          amp_d = wr_data[1:0];
        end
        8'd2: slew_d  = wr_data;
        8'd3: slew8_d = wr_data[0];
        8'd7: cnt_d   = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 8'hFF;
      en8_q   <= 1'b1;
      amp_q   <= 2'b10;
      slew_q  <= 8'hFF;
      slew8_q <= 1'b1;
      cnt_q   <= CNT_RST;
    end else begin
      en_q    <= en_d;
      en8_q   <= en8_d;
      amp_q   <= amp_d;
      slew_q  <= slew_d;
      slew8_q <= slew8_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    case (rd_idx)
      8'd0:    rd_data = en_q;
      8'd1:    rd_data = {2'b00, en8_q, 3'b000, amp_q};
      8'd2:    rd_data = slew_q;
      8'd3:    rd_data = {7'd0, slew8_q};
      8'd5:    rd_data = ID_VENDOR;
      8'd6:    rd_data = ID_DEVICE;
      8'd7:    rd_data = {{(BYTE_W-CNT_W){1'b0}}, cnt_q};
      default: rd_data = FILL_BYTE;
    endcase
  end

  assign rd_count  = cnt_q;
  assign lane_en   = {en8_q, en_q};
  assign amp_sel   = amp_q;
  assign slew_fast = {slew8_q, slew_q};

  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({en_q, en8_q, amp_q, slew_q, slew8_q, cnt_q})); // R3

  AST_RO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx > 8'd7 || wr_idx == 8'd4 || wr_idx == 8'd5 || wr_idx == 8'd6))
    |=> $stable({en_q, en8_q, amp_q, slew_q, slew8_q, cnt_q})); // R6

endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  rd_count,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx
);

  link_st_t          st_q, st_d;
  after_ack_t        nx_q, nx_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [3:0]        bit_q, bit_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] left_q, left_d;
  logic              idxv_q, idxv_d;
  logic              hack_q, hack_d;
  logic              oe_q, oe_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[7:1] == dev_addr) && (!sh_q[0] || idxv_q);

  always_comb begin
    st_d   = st_q;
    nx_d   = nx_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    idx_d  = idx_q;
    left_d = left_q;
    idxv_d = idxv_q;
    hack_d = hack_q;
    oe_d   = oe_q;
    wr_en  = 1'b0;
    if (!bus_en) begin
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
      idxv_d = 1'b0;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      bit_d = 4'd0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
      idxv_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
          if (scl_rise && bit_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            st_d = ST_ACK;
            oe_d = 1'b1;
            case (st_q)
              ST_ADDR: begin
                nx_d = sh_q[0] ? NX_TXCNT : NX_INDEX;
                if (!addr_hit) begin
                  st_d = ST_IDLE;
                  oe_d = 1'b0;
                end
              end
              ST_INDEX: begin
                idx_d  = sh_q;
                idxv_d = 1'b1;
                nx_d   = NX_COUNT;
              end
              ST_COUNT: begin
                left_d = sh_q;
                nx_d   = NX_WDATA;
              end
              default: begin
                nx_d = NX_WDATA;
                if (left_q != '0) begin
                  wr_en  = 1'b1;
                  idx_d  = idx_q + 1'b1;
                  left_d = left_q - 1'b1;
                end else begin
                  st_d = ST_IDLE;
                  oe_d = 1'b0;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            bit_d = 4'd0;
            case (nx_q)
              NX_INDEX: st_d = ST_INDEX;
              NX_COUNT: st_d = ST_COUNT;
              NX_WDATA: st_d = ST_WDATA;
              default: begin
                st_d = ST_TX;
                sh_d = {{(BYTE_W-CNT_W){1'b0}}, rd_count};
                oe_d = ~sh_d[7];
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d = 1'b0;
              st_d = ST_TX_ACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              st_d  = ST_TX;
              sh_d  = rd_data;
              oe_d  = ~rd_data[7];
              bit_d = 4'd0;
              idx_d = idx_q + 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      nx_q   <= NX_INDEX;
      sh_q   <= '0;
      bit_q  <= '0;
      idx_q  <= '0;
      left_q <= '0;
      idxv_q <= 1'b0;
      hack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      nx_q   <= nx_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      idx_q  <= idx_d;
      left_q <= left_d;
      idxv_q <= idxv_d;
      hack_q <= hack_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_idx  = idx_q;
  assign wr_data = sh_q;
  assign rd_idx  = idx_q;

  AST_IDLE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !oe_q); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && stop_det) |=> !oe_q); // R9

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s); // R10

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_present,
  input  logic       pwrgd,
  input  logic [1:0] addr_strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [8:0] lane_en,
  output logic [1:0] amp_sel,
  output logic [8:0] slew_fast
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] dev_addr;
  logic              addr_valid;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  rd_count;

  smb_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  smb_addr_strap u_strap (
    .clk, .rst_n, .pwrgd, .addr_strap, .dev_addr, .addr_valid
  );

  smb_link_fsm u_link (
    .clk, .rst_n,
    .bus_en(clk_present & addr_valid),
    .dev_addr, .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_data, .rd_count, .sda_oe, .wr_en, .wr_idx, .wr_data, .rd_idx
  );

  smb_reg_bank u_bank (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .rd_idx, .rd_data, .rd_count,
    .lane_en, .amp_sel, .slew_fast
  );

endmodule

// File: tb/smb_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module smb_cfg_slave_tb_top;

  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n, clk_present, pwrgd;
  logic [1:0] addr_strap;
  logic       scl_m, sda_m;
  logic       sda_oe;
  logic [8:0] lane_en, slew_fast;
  logic [1:0] amp_sel;
  wire        sda_bus = sda_m & ~sda_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int r10_viol = 0;
  logic prev_oe = 1'b0;

  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:8];
  logic       ok, ack;

  always #4 clk = ~clk;

  smb_cfg_slave dut_i (
    .clk, .rst_n, .clk_present, .pwrgd, .addr_strap,
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe,
    .lane_en, .amp_sel, .slew_fast
  );

  // R10 monitor: slave must start pulling SDA only while SCL is low
  always @(posedge clk) begin
    #1;
    if (sda_oe && !prev_oe && scl_m) r10_viol++;
    prev_oe = sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(Q); sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wait_clk(Q); sda_m = b[i]; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2*Q);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    send_bits(b, 8);
    wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    a = ~sda_bus;
    wait_clk(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(2*Q); scl_m = 1'b1; wait_clk(Q);
      b = {b[6:0], sda_bus};
      wait_clk(Q); scl_m = 1'b0;
    end
    wait_clk(Q); sda_m = ~give_ack; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(1); sda_m = 1'b1;
  endtask

  task automatic probe(input logic [6:0] a, input logic rd, output logic a_ok);
    bus_start();
    send_byte({a, rd}, a_ok);
    bus_stop();
  endtask

  task automatic wr_block(input logic [6:0] a, input logic [7:0] idx, input int n, output logic all_ok);
    all_ok = 1'b1;
    bus_start();
    send_byte({a, 1'b0}, ack); all_ok &= ack;
    send_byte(idx, ack); all_ok &= ack;
    send_byte(8'(n), ack); all_ok &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); all_ok &= ack;
    end
    bus_stop();
  endtask

  task automatic rd_block(input logic [6:0] a, input logic [7:0] idx, input int n, output logic all_ok);
    all_ok = 1'b1;
    bus_start();
    send_byte({a, 1'b0}, ack); all_ok &= ack;
    send_byte(idx, ack); all_ok &= ack;
    bus_rstart();
    send_byte({a, 1'b1}, ack); all_ok &= ack;
    recv_byte(1'b1, rbuf[0]);
    for (int i = 1; i <= n; i++) recv_byte(i < n, rbuf[i]);
    bus_stop();
  endtask

  task automatic do_reset(input logic [1:0] strap, input logic raise_pg);
    rst_n = 1'b0; pwrgd = 1'b0; clk_present = 1'b1; addr_strap = strap;
    scl_m = 1'b1; sda_m = 1'b1;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    if (raise_pg) begin pwrgd = 1'b1; wait_clk(6); end
  endtask

  task automatic t_reset();
    logic [7:0] exp [0:8];
    exp = '{8'h08, 8'hFF, 8'h22, 8'hFF, 8'h01, 8'hFF, 8'h01, 8'hC9, 8'h08};
    chk("R5 lane_en reset", 16'(lane_en), 16'h1FF);
    chk("R5 slew_fast reset", 16'(slew_fast), 16'h1FF);
    chk("R5 amp_sel reset", 16'(amp_sel), 16'h2);
    rd_block(7'h6B, 8'd0, 8, ok);
    chk("R4 read acks", 16'(ok), 16'h1);
    for (int i = 0; i <= 8; i++) chk("R5 R7 reset readback", 16'(rbuf[i]), 16'(exp[i]));
  endtask

  task automatic t_write();
    wbuf[0] = 8'h5A; wbuf[1] = 8'h13; wbuf[2] = 8'hA5;
    wr_block(7'h6B, 8'd0, 3, ok);
    chk("R3 write acks", 16'(ok), 16'h1);
    chk("R3 R6 lane_en", 16'(lane_en), 16'h05A);
    chk("R3 amp_sel", 16'(amp_sel), 16'h3);
    chk("R3 slew_fast", 16'(slew_fast), 16'h1A5);
    bus_start();
    send_byte({7'h6B, 1'b0}, ack);
    send_byte(8'd0, ack);
    send_byte(8'd1, ack);
    send_byte(8'h11, ack);
    chk("R3 last counted byte ack", 16'(ack), 16'h1);
    send_byte(8'h22, ack);
    chk("R3 byte past count nack", 16'(ack), 16'h0);
    bus_stop();
    chk("R3 extra byte not stored", 16'(lane_en), 16'h011);
  endtask

  task automatic t_read();
    rd_block(7'h6B, 8'd1, 3, ok);
    chk("R4 read acks", 16'(ok), 16'h1);
    chk("R4 count first", 16'(rbuf[0]), 16'h08);
    chk("R4 byte N", 16'(rbuf[1]), 16'h03);
    chk("R4 byte N+1", 16'(rbuf[2]), 16'hA5);
    chk("R4 byte N+2", 16'(rbuf[3]), 16'h01);
  endtask

  task automatic t_readonly();
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
    wr_block(7'h6B, 8'd4, 3, ok);
    chk("R6 ro write acked", 16'(ok), 16'h1);
    rd_block(7'h6B, 8'd4, 4, ok);
    chk("R6 byte4", 16'(rbuf[1]), 16'hFF);
    chk("R6 byte5", 16'(rbuf[2]), 16'h01);
    chk("R6 byte6", 16'(rbuf[3]), 16'hC9);
    chk("R6 byte7", 16'(rbuf[4]), 16'h08);
    rd_block(7'h6B, 8'd8, 2, ok);
    chk("R6 idx8 reads FF", 16'(rbuf[1]), 16'hFF);
    chk("R6 idx9 reads FF", 16'(rbuf[2]), 16'hFF);
    wbuf[0] = 8'hFE;
    wr_block(7'h6B, 8'd3, 1, ok);
    chk("R6 byte3 mask", 16'(slew_fast), 16'h0A5);
    rd_block(7'h6B, 8'd3, 1, ok);
    chk("R6 byte3 readback", 16'(rbuf[1]), 16'h00);
  endtask

  task automatic t_count();
    wbuf[0] = 8'h03;
    wr_block(7'h6B, 8'd7, 1, ok);
    rd_block(7'h6B, 8'd0, 1, ok);
    chk("R7 count byte", 16'(rbuf[0]), 16'h03);
    wbuf[0] = 8'hE5;
    wr_block(7'h6B, 8'd7, 1, ok);
    rd_block(7'h6B, 8'd7, 1, ok);
    chk("R7 R6 count masked", 16'(rbuf[0]), 16'h05);
    chk("R7 byte7 readback", 16'(rbuf[1]), 16'h05);
    wbuf[0] = 8'h08;
    wr_block(7'h6B, 8'd7, 1, ok);
  endtask

  task automatic t_noclk();
    clk_present = 1'b0; wait_clk(2);
    probe(7'h6B, 1'b0, ok);
    chk("R8 no ack without clock", 16'(ok), 16'h0);
    wbuf[0] = 8'h00;
    wr_block(7'h6B, 8'd0, 1, ok);
    chk("R8 no store without clock", 16'(lane_en), 16'h011);
    clk_present = 1'b1; wait_clk(2);
    probe(7'h6B, 1'b0, ok);
    chk("R8 ack with clock back", 16'(ok), 16'h1);
  endtask

  task automatic t_abort();
    bus_start();
    send_byte({7'h6B, 1'b0}, ack);
    send_byte(8'd0, ack);
    send_byte(8'd1, ack);
    send_bits(8'h00, 4);
    bus_stop();
    chk("R9 stop mid byte no store", 16'(lane_en), 16'h011);
    probe(7'h6B, 1'b1, ok);
    chk("R9 read without index nack", 16'(ok), 16'h0);
    bus_start();
    send_byte({7'h6B, 1'b0}, ack);
    send_byte(8'd0, ack);
    send_byte(8'd1, ack);
    send_bits(8'h00, 3);
    bus_rstart();
    send_byte({7'h6B, 1'b0}, ack);
    send_byte(8'd2, ack);
    send_byte(8'd1, ack);
    send_byte(8'h0F, ack);
    bus_stop();
    chk("R9 restart abort no store", 16'(lane_en), 16'h011);
    chk("R9 fresh write after restart", 16'(slew_fast), 16'h00F);
  endtask

  task automatic t_strap();
    logic [6:0] addrs [0:2];
    addrs = '{7'h6B, 7'h6C, 7'h6D};
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s), 1'b1);
      for (int k = 0; k < 3; k++) begin
        probe(addrs[k], 1'b0, ok);
        chk("R1 strap address decode", 16'(ok), 16'((k == s) || (s == 3 && k == 1)));
      end
    end
  endtask

  task automatic t_strap_once();
    do_reset(2'b00, 1'b0);
    probe(7'h6B, 1'b0, ok);
    chk("R2 no ack before power-good", 16'(ok), 16'h0);
    pwrgd = 1'b1; wait_clk(6);
    addr_strap = 2'b10;
    pwrgd = 1'b0; wait_clk(6);
    pwrgd = 1'b1; wait_clk(6);
    probe(7'h6B, 1'b0, ok);
    chk("R2 first strap kept", 16'(ok), 16'h1);
    probe(7'h6D, 1'b0, ok);
    chk("R2 later strap ignored", 16'(ok), 16'h0);
  endtask

  initial begin
    do_reset(2'b00, 1'b1);
    t_reset();
    t_write();
    t_read();
    t_readonly();
    t_count();
    t_noclk();
    t_abort();
    t_strap();
    t_strap_once();
    chk("R10 drive only while SCL low", 16'(r10_viol), 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule